// File: doc/BRIEF.md
# Strobe-Handshake Register Interface for a Serial Bus Controller

This block is the processor-facing slave port of a byte-wide serial bus controller. A host master presents a 24-bit address, a read/write level and an 8-bit data byte, then pulls its address strobe and data strobe low. The interface decodes the access and performs it. It answers with an active-low acknowledge, which it holds until the host raises both strobes again. Read data goes onto a shared bidirectional bus only while the acknowledged read is still strobed. At every other time the bus is left floating.

Behind the port sit four byte registers: own address, control, status and data. The control byte drives the serial bus engine directly. The engine reports its line state through level inputs and two event pulses, which the status byte collects. A data write gives the engine its next transmit byte, together with a one-cycle load strobe. A data read returns the byte the engine last delivered. An interrupt request combines the interrupt flag with the interrupt enable.

Top module: `strobe_regif`

## Requirements
- R1: A clock edge with rst_n low clears every register, so control, own address, status, data and irq all read or show 0.
- R2: An access is decoded only when cpu_addr[23:8] equals BASE (default 0) and cpu_addr[7:0] is 0x8D (own address), 0x91 (control), 0x93 (status) or 0x95 (data). Any other address is still acknowledged, but a write there changes nothing and a read there returns 0x00.
- R3: An access starts when both active-low strobes are seen low. cpu_ack_n then goes low and stays low while either strobe is low. It returns high within two clock edges after both strobes are high.
- R4: cpu_data is driven only while a read access is acknowledged and both strobes are low. cpu_rd_wr_n high means read and low means write. Otherwise the bus is high impedance.
- R5: The control byte holds, from bit 7 down, enable, interrupt enable, master/start, transmit select, acknowledge disable and repeated start. Bits 1:0 are reserved: they read 0 and ignore writes. ctrl_bits shows the stored byte.
- R6: The status byte holds, from bit 7 down, transfer done, addressed as slave, bus busy, arbitration lost, reserved (always 0), slave read, interrupt flag and received acknowledge. Bits 7, 6, 5, 2 and 0 follow the engine level inputs one clock later, and host writes do not change them.
- R7: Arbitration lost (bit 4) and interrupt flag (bit 1) are set by the engine pulses eng_arb_set and eng_irq_set. Writing 0 to one of these bits clears it, and writing 1 leaves it unchanged. An engine set in the same cycle as a clear wins.
- R8: A write to the data register places the byte on tx_data and pulses tx_load high for exactly one clock.
- R9: A read of the data register returns the byte last captured from rx_data on an rx_load pulse.
- R10: irq is high exactly when control bit 6 and status bit 1 are both set. It rises on the edge after an eng_irq_set pulse when enabled.
- R11: The own-address register stores all 8 written bits, reads them back, and drives own_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 24 | Host address |
| cpu_data | inout | 8 | Bidirectional host data bus |
| cpu_as_n | input | 1 | Address strobe, active low |
| cpu_ds_n | input | 1 | Data strobe, active low |
| cpu_rd_wr_n | input | 1 | 1 = read, 0 = write |
| cpu_ack_n | output | 1 | Transfer acknowledge, active low |
| irq | output | 1 | Interrupt request |
| ctrl_bits | output | 8 | Stored control byte to the engine |
| own_addr | output | 8 | Stored own-address byte |
| tx_data | output | 8 | Next byte to transmit |
| tx_load | output | 1 | One-cycle pulse on a data write |
| rx_data | input | 8 | Byte received by the engine |
| rx_load | input | 1 | Capture pulse for rx_data |
| eng_done | input | 1 | Transfer done level |
| eng_slave_hit | input | 1 | Addressed as slave level |
| eng_busy | input | 1 | Bus busy level |
| eng_slave_rd | input | 1 | Slave read direction level |
| eng_rx_ack | input | 1 | Received acknowledge level |
| eng_arb_set | input | 1 | Arbitration lost event pulse |
| eng_irq_set | input | 1 | Interrupt flag event pulse |

## Verification
On every cycle, the assertions check three things: the data bus is driven only inside an acknowledged read window, the acknowledge is released after the strobes have been high long enough, and a transmit load is a single-cycle pulse inside a write acknowledge. They also check that an enabled flag event raises irq on the next edge. Only the bench scenarios can show the register map contents, reserved-bit masking, clear-by-zero of the sticky bits, that unmapped accesses have no effect, and the byte returned by each read. These are checked against a bench-side model over random access mixes and directed corner cases.

// File: rtl/strobe_regif.sv
module strobe_regif #(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-9:0] BASE = '0,
  parameter logic [7:0] OFF_OWN  = 8'h8D,
  parameter logic [7:0] OFF_CTRL = 8'h91,
  parameter logic [7:0] OFF_STAT = 8'h93,
  parameter logic [7:0] OFF_DATA = 8'h95
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  inout  wire  [7:0]        cpu_data,
  input  logic              cpu_as_n,
  input  logic              cpu_ds_n,
  input  logic              cpu_rd_wr_n,
  output logic              cpu_ack_n,
  output logic              irq,
  output logic [7:0]        ctrl_bits,
  output logic [7:0]        own_addr,
  output logic [7:0]        tx_data,
  output logic              tx_load,
  input  logic [7:0]        rx_data,
  input  logic              rx_load,
  input  logic              eng_done,
  input  logic              eng_slave_hit,
  input  logic              eng_busy,
  input  logic              eng_slave_rd,
  input  logic              eng_rx_ack,
  input  logic              eng_arb_set,
  input  logic              eng_irq_set
);
  localparam logic [7:0] CTRL_MASK = 8'hFC;

  logic       as_q, ds_q, busy_q, rd_act;
  logic [7:0] rd_q, rd_mux, rx_q;
  logic [4:0] live_q;
  logic       arb_q, flag_q;
  logic       hit, sel_own, sel_ctrl, sel_stat, sel_data;
  logic       commit, wr_go, drv;
  logic [7:0] wdata, stat_byte;

  assign hit      = cpu_addr[ADDR_W-1:8] == BASE;
  assign sel_own  = hit && cpu_addr[7:0] == OFF_OWN;
  assign sel_ctrl = hit && cpu_addr[7:0] == OFF_CTRL;
  assign sel_stat = hit && cpu_addr[7:0] == OFF_STAT;
  assign sel_data = hit && cpu_addr[7:0] == OFF_DATA;

  assign commit = !busy_q && !as_q && !ds_q;
  assign wr_go  = commit && !cpu_rd_wr_n;
  assign wdata  = cpu_data;

  assign stat_byte = {live_q[4], live_q[3], live_q[2], arb_q, 1'b0,
                      live_q[1], flag_q, live_q[0]};

  always_comb begin
    rd_mux = 8'h00;
    if (sel_own)  rd_mux = own_addr;
    if (sel_ctrl) rd_mux = ctrl_bits;
    if (sel_stat) rd_mux = stat_byte;
    if (sel_data) rd_mux = rx_q;
  end

  assign cpu_ack_n = !busy_q;
  assign drv       = busy_q && rd_act && !cpu_as_n && !cpu_ds_n;
  assign cpu_data  = drv ? rd_q : 8'hzz;
  assign irq       = ctrl_bits[6] && flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      as_q <= 1'b1;
      ds_q <= 1'b1;
    end else begin
      as_q <= cpu_as_n;
      ds_q <= cpu_ds_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_act <= 1'b0;
      rd_q   <= 8'h00;
    end else if (commit) begin
      busy_q <= 1'b1;
      rd_act <= cpu_rd_wr_n;
      rd_q   <= rd_mux;
    end else if (busy_q && as_q && ds_q) begin
      busy_q <= 1'b0;
      rd_act <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_addr  <= 8'h00;
      ctrl_bits <= 8'h00;
      tx_data   <= 8'h00;
      tx_load   <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      if (wr_go && sel_own)  own_addr  <= wdata;
      if (wr_go && sel_ctrl) ctrl_bits <= wdata & CTRL_MASK;
      if (wr_go && sel_data) begin
        tx_data <= wdata;
        tx_load <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 5'b0;
      arb_q  <= 1'b0;
      flag_q <= 1'b0;
      rx_q   <= 8'h00;
    end else begin
      live_q <= {eng_done, eng_slave_hit, eng_busy, eng_slave_rd, eng_rx_ack};
      if (rx_load) rx_q <= rx_data;
      if (eng_arb_set) arb_q <= 1'b1;
      else if (wr_go && sel_stat && !wdata[4]) arb_q <= 1'b0;
      if (eng_irq_set) flag_q <= 1'b1;
      else if (wr_go && sel_stat && !wdata[1]) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/strobe_regif_chk.sv
module strobe_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_as_n,
  input logic       cpu_ds_n,
  input logic       cpu_rd_wr_n,
  input logic       cpu_ack_n,
  input logic       drv,
  input logic       tx_load,
  input logic       irq,
  input logic [7:0] ctrl_bits,
  input logic       eng_irq_set
);
  // R4
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> (!cpu_ack_n && cpu_rd_wr_n));

  // R3
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_as_n && cpu_ds_n && $past(cpu_as_n && cpu_ds_n)) |=> cpu_ack_n);

  // R8
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);

  // R8
  load_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (!cpu_ack_n && !cpu_rd_wr_n));

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_irq_set && ctrl_bits[6] && cpu_ack_n) |=> irq);
endmodule

bind strobe_regif strobe_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_ds_n(cpu_ds_n),
  .cpu_rd_wr_n(cpu_rd_wr_n), .cpu_ack_n(cpu_ack_n), .drv(drv),
  .tx_load(tx_load), .irq(irq), .ctrl_bits(ctrl_bits), .eng_irq_set(eng_irq_set)
);

// File: tb/sim_strobe_regif.sv
`timescale 1ns/1ps
module sim_strobe_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] cpu_addr = '0;
  wire  [7:0]  cpu_data;
  logic        cpu_as_n = 1'b1, cpu_ds_n = 1'b1, cpu_rd_wr_n = 1'b1;
  logic        cpu_ack_n, irq, tx_load;
  logic [7:0]  ctrl_bits, own_addr, tx_data;
  logic [7:0]  rx_data = '0;
  logic        rx_load = 0, eng_done = 0, eng_slave_hit = 0, eng_busy = 0;
  logic        eng_slave_rd = 0, eng_rx_ack = 0, eng_arb_set = 0, eng_irq_set = 0;
  logic        drv_en = 1'b0;
  logic [7:0]  drv_val = '0;

  int checks = 0, fails = 0, loads = 0;
  bit finished = 0;

  logic [7:0] m_own = 0, m_ctrl = 0, m_rx = 0;
  logic       m_arb = 0, m_flag = 0;

  assign cpu_data = drv_en ? drv_val : 8'hzz;

  always #4 clk = ~clk;
  always @(posedge clk) if (tx_load) loads++;

  strobe_regif u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_as_n(cpu_as_n), .cpu_ds_n(cpu_ds_n), .cpu_rd_wr_n(cpu_rd_wr_n),
    .cpu_ack_n(cpu_ack_n), .irq(irq), .ctrl_bits(ctrl_bits), .own_addr(own_addr),
    .tx_data(tx_data), .tx_load(tx_load), .rx_data(rx_data), .rx_load(rx_load),
    .eng_done(eng_done), .eng_slave_hit(eng_slave_hit), .eng_busy(eng_busy),
    .eng_slave_rd(eng_slave_rd), .eng_rx_ack(eng_rx_ack),
    .eng_arb_set(eng_arb_set), .eng_irq_set(eng_irq_set));

  localparam logic [23:0] A_OWN = 24'h00008D, A_CTRL = 24'h000091,
                          A_STAT = 24'h000093, A_DATA = 24'h000095;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [23:0] a);
    if (a == A_OWN)  return m_own;
    if (a == A_CTRL) return m_ctrl;
    if (a == A_STAT) return {eng_done, eng_slave_hit, eng_busy, m_arb, 1'b0,
                             eng_slave_rd, m_flag, eng_rx_ack};
    if (a == A_DATA) return m_rx;
    return 8'h00;
  endfunction

  task automatic model_write(input logic [23:0] a, input logic [7:0] d);
    if (a == A_OWN)  m_own = d;
    if (a == A_CTRL) m_ctrl = d & 8'hFC;
    if (a == A_STAT) begin
      if (!d[4]) m_arb = 0;
      if (!d[1]) m_flag = 0;
    end
  endtask

  task automatic access(input logic [23:0] a, input logic rd,
                        input logic [7:0] wd, output logic [7:0] rdata);
    int n;
    @(negedge clk);
    cpu_addr = a; cpu_rd_wr_n = rd; drv_en = !rd; drv_val = wd;
    cpu_as_n = 0; cpu_ds_n = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (cpu_ack_n && n < 20);
    check("R3 ack low", {7'd0, cpu_ack_n}, 8'd0);
    rdata = cpu_data;
    cpu_as_n = 1; cpu_ds_n = 1;
    @(negedge clk); @(negedge clk);
    check("R3 ack release", {7'd0, cpu_ack_n}, 8'd1);
    drv_en = 0;
  endtask

  task automatic wr(input logic [23:0] a, input logic [7:0] d);
    logic [7:0] x;
    access(a, 1'b0, d, x);
    model_write(a, d);
  endtask

  task automatic rd_chk(input string req, input logic [23:0] a);
    logic [7:0] x;
    access(a, 1'b1, 8'h00, x);
    check(req, x, exp_read(a));
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  initial begin
    int l0;
    logic [23:0] a;
    logic [7:0] d;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctrl", ctrl_bits, 0);
    check("R1 irq", {7'd0, irq}, 0);
    rd_chk("R1 own", A_OWN); rd_chk("R1 ctrl rd", A_CTRL);
    rd_chk("R1 stat", A_STAT); rd_chk("R1 data", A_DATA);
    // R11 own address full byte
    wr(A_OWN, 8'hA5); rd_chk("R11 own", A_OWN);
    check("R11 own_addr", own_addr, 8'hA5);
    // R5 reserved control bits
    wr(A_CTRL, 8'hFF); rd_chk("R5 ctrl", A_CTRL);
    check("R5 ctrl_bits", ctrl_bits, 8'hFC);
    // R2 unmapped: upper bits nonzero and bad offset
    wr(24'h01008D, 8'h11); rd_chk("R2 base miss", A_OWN);
    wr(24'h000090, 8'h00); rd_chk("R2 offset miss", A_CTRL);
    rd_chk("R2 unmapped read", 24'h000092);
    // R8 data write
    l0 = loads;
    wr(A_DATA, 8'h3C);
    check("R8 tx_data", tx_data, 8'h3C);
    check("R8 one pulse", 8'(loads - l0), 8'd1);
    // R9 receive
    @(negedge clk); rx_data = 8'hC3; pulse(rx_load); m_rx = 8'hC3;
    rx_data = 8'h00;
    rd_chk("R9 rx", A_DATA);
    // R6 live bits, writes ignored
    eng_done = 1; eng_busy = 1; eng_rx_ack = 1;
    repeat (2) @(negedge clk);
    rd_chk("R6 live", A_STAT);
    wr(A_STAT, 8'h00); rd_chk("R6 write ignored", A_STAT);
    // R7 / R10 sticky and irq
    pulse(eng_irq_set); m_flag = 1;
    check("R10 irq high", {7'd0, irq}, 1);
    pulse(eng_arb_set); m_arb = 1;
    rd_chk("R7 set", A_STAT);
    wr(A_STAT, 8'hFF); rd_chk("R7 write one no effect", A_STAT);
    wr(A_CTRL, 8'h80); check("R10 irq masked", {7'd0, irq}, 0);
    wr(A_CTRL, 8'h40); check("R10 irq enabled", {7'd0, irq}, 1);
    wr(A_STAT, 8'hEF); rd_chk("R7 clear arb", A_STAT);
    wr(A_STAT, 8'hFD); rd_chk("R7 clear flag", A_STAT);
    check("R10 irq cleared", {7'd0, irq}, 0);
    // R1 reset again
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    m_own = 0; m_ctrl = 0; m_rx = 0; m_arb = 0; m_flag = 0;
    eng_done = 0; eng_busy = 0; eng_rx_ack = 0;
    @(negedge clk);
    rd_chk("R1 reset own", A_OWN); check("R1 reset tx", tx_data, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 5))
        0: a = A_OWN; 1: a = A_CTRL; 2: a = A_STAT; 3: a = A_DATA;
        4: a = {16'h0000, 8'($urandom)};
        default: a = 24'($urandom);
      endcase
      d = 8'($urandom);
      if (i % 50 == 0) begin
        {eng_done, eng_slave_hit, eng_busy, eng_slave_rd, eng_rx_ack} = 5'($urandom);
        repeat (2) @(negedge clk);
      end
      if ($urandom_range(0, 1)) begin
        l0 = loads;
        wr(a, d);
        if (a == A_DATA) begin
          check("R8 rand tx", tx_data, d);
          check("R8 rand pulse", 8'(loads - l0), 8'd1);
        end
      end else rd_chk("R2 rand read", a);
    end
    check("R11 final own_addr", own_addr, m_own);
    check("R5 final ctrl", ctrl_bits, m_ctrl);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule